// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the software-visible control state for one bus-master disk DMA channel. Its eight-byte register window has a command byte at offset 0, a status byte at offset 2, and a 32-bit pointer to the descriptor table at offset 4. Offsets 1 and 3 are reserved for vendor use and are not implemented here. Software reaches the window through a simple write strobe. Each access is either one byte or one aligned dword, and reads are combinational.

The block drives a run request, a transfer direction and the descriptor table base toward a separate DMA engine. The engine reports three things back: a busy level, a one-cycle error pulse and a one-cycle completion-interrupt pulse. The status byte holds three kinds of bits. The active bit is set by the engine and cannot be written. The error and interrupt bits are set by events and cleared by writing 1. The two drive-capable flags are plain read/write storage. The interrupt output follows the interrupt status bit.

Top module: `bmdma_regs`

## Requirements
- R1: After a synchronous active-low reset, the command, status and pointer registers read 0, and eng_run, eng_to_mem, eng_table_base and irq are 0.
- R2: Writing command bit 0 as 1 raises eng_run after the write's clock edge. Writing it as 0 lowers eng_run. Command reads show the run flag in bit 0.
- R3: Command bit 3 sets the direction. A value of 1 (device to memory) drives eng_to_mem to 1, and 0 (memory to device) drives it to 0. All other command bits read 0.
- R4: Status bit 0 (active) reads 1 only while eng_busy is high and the run flag is set. Writes to status bit 0 have no effect.
- R5: A command write that clears bit 0 while a transfer is active drops both eng_run and status bit 0 at that write's clock edge.
- R6: A pulse on eng_err_evt sets status bit 1, and a pulse on eng_irq_evt sets status bit 2. Each bit stays set until software writes 1 to it. Writing 0 leaves it unchanged. If an event and a clearing write arrive in the same cycle, the bit ends up set.
- R7: The irq output equals status bit 2.
- R8: Status bits 5 and 6 (drive 0 and drive 1 DMA-capable) keep the values written to them. Status bits 3, 4 and 7 always read 0.
- R9: The descriptor pointer at offsets 4 to 7 accepts byte writes and dword writes. Address bits [1:0] always read 0, and eng_table_base equals the value read back.
- R10: Offsets 1 and 3 read 0, and writes to them change nothing.
- R11: A byte read returns the addressed byte in bits [7:0] with bits [31:8] zero. A dword access uses address bit 2 to pick the word and ignores address bits [1:0]. Byte k of the word is carried on bits [8k+7:8k].
- R12: After a transfer that ends cleanly (busy falls, interrupt event, no error), status bits [2:0] read exactly 100b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_dword | input | 1 | Access size: 1 dword, 0 byte |
| reg_addr | input | 3 | Byte offset within the window |
| reg_wdata | input | 32 | Write data (byte writes use bits [7:0]) |
| reg_rdata | output | 32 | Combinational read data |
| eng_run | output | 1 | Run request to the DMA engine |
| eng_to_mem | output | 1 | Direction: 1 device to memory |
| eng_table_base | output | 32 | Descriptor table base, dword aligned |
| eng_busy | input | 1 | Engine is moving data |
| eng_err_evt | input | 1 | One-cycle error event |
| eng_irq_evt | input | 1 | One-cycle completion event |
| irq | output | 1 | Interrupt request |

## Verification
The status byte is exercised with a separate pattern for each kind of bit. One pattern holds eng_busy high while software tries to write the active bit, which tells read-only behaviour apart from storage. Another pulses events and then writes 0 and 1 to the sticky bits, which separates write-one-to-clear from plain storage. A third makes an event and a clearing write coincide, which shows which one wins. An abort in the middle of a transfer, set against a clean completion, separates an active bit that is gated by the run flag from a full transfer that ends with status 100b. Byte and dword writes with misaligned values at the pointer offsets confirm lane steering and the forced alignment.

// File: rtl/bmdma_pkg.sv
// Package: shared offsets and bit positions for the bus-master DMA register window.
// Assumes an eight-byte window made of two 32-bit words.
package bmdma_pkg;
    localparam int WIN_BYTES  = 8;
    localparam int WIN_AW     = $clog2(WIN_BYTES);
    localparam int OFF_CMD    = 0;
    localparam int OFF_VEND1  = 1;
    localparam int OFF_STS    = 2;
    localparam int OFF_VEND3  = 3;
    localparam int OFF_PTR    = 4;
    localparam int PTR_BYTES  = 4;
    localparam int PTR_ALIGN  = 2;
    // command byte fields
    localparam int CMD_RUN    = 0;
    localparam int CMD_TOMEM  = 3;
    // status byte fields
    localparam int STS_ACT    = 0;
    localparam int STS_ERR    = 1;
    localparam int STS_IRQ    = 2;
    localparam int STS_CAP0   = 5;
    localparam int STS_CAP1   = 6;

    typedef logic [7:0] byte_t;
endpackage

// File: rtl/bmdma_lane.sv
// Module: byte-lane steering for the register window.
// Turns a byte or dword access into per-byte write enables and write data,
// and assembles read data from the window's byte images.
// Assumes: byte writes take data on wdata[7:0]; a dword access ignores addr[1:0].
module bmdma_lane #(
    parameter int NBYTES = 8,
    localparam int AW    = $clog2(NBYTES),
    localparam int NWORD = NBYTES / 4
) (
    input  logic                        wr_en,
    input  logic                        dword,
    input  logic [AW-1:0]               addr,
    input  logic [31:0]                 wdata,
    input  logic [NBYTES-1:0][7:0]      rd_bytes,
    output logic [NBYTES-1:0]           wr_be,
    output logic [NBYTES-1:0][7:0]      wr_bytes,
    output logic [31:0]                 rdata
);
    // per-byte write enable and data selection
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam int WORD = i / 4;
        localparam int LANE = i % 4;
        logic word_hit;
        assign word_hit    = (int'(addr[AW-1:2]) == WORD);
        assign wr_be[i]    = wr_en && word_hit && (dword || (int'(addr[1:0]) == LANE));
        assign wr_bytes[i] = dword ? wdata[8*LANE +: 8] : wdata[7:0];
    end

    // read data assembly: whole word or one byte in the low lane
    always_comb begin
        rdata = '0;
        if (dword) begin
            for (int k = 0; k < 4; k++) begin
                rdata[8*k +: 8] = rd_bytes[{addr[AW-1:2], 2'(k)}];
            end
        end else begin
            rdata[7:0] = rd_bytes[addr];
        end
    end
endmodule

// File: rtl/bmdma_ctrl.sv
// Module: command and status bytes of one DMA channel.
// Holds run and direction flags, the engine-driven active bit, the sticky
// error and interrupt bits (write one to clear, event wins), and the two
// drive-capable flags. Assumes event inputs are single-cycle pulses.
module bmdma_ctrl
    import bmdma_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_we,
    input  byte_t cmd_wd,
    input  logic  sts_we,
    input  byte_t sts_wd,
    input  logic  eng_busy,
    input  logic  err_evt,
    input  logic  irq_evt,
    output byte_t cmd_byte,
    output byte_t sts_byte,
    output logic  run,
    output logic  to_mem,
    output logic  irq
);
    logic       run_q, tomem_q, act_q, err_q, irq_q;
    logic [1:0] cap_q;
    logic       run_next;

    // value the run flag takes at the coming edge
    assign run_next = cmd_we ? cmd_wd[CMD_RUN] : run_q;

    // command flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            tomem_q <= 1'b0;
        end else if (cmd_we) begin
            run_q   <= cmd_wd[CMD_RUN];
            tomem_q <= cmd_wd[CMD_TOMEM];
        end
    end

    // active bit follows the engine only while running
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= run_next && eng_busy;
    end

    // sticky event bits: set by event, cleared by writing 1, event has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            err_q <= err_evt || (err_q && !(sts_we && sts_wd[STS_ERR]));
            irq_q <= irq_evt || (irq_q && !(sts_we && sts_wd[STS_IRQ]));
        end
    end

    // drive-capable flags are plain storage
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= 2'b00;
        else if (sts_we) cap_q <= {sts_wd[STS_CAP1], sts_wd[STS_CAP0]};
    end

    // read images of the two bytes
    always_comb begin
        cmd_byte            = '0;
        cmd_byte[CMD_RUN]   = run_q;
        cmd_byte[CMD_TOMEM] = tomem_q;
        sts_byte            = '0;
        sts_byte[STS_ACT]   = act_q;
        sts_byte[STS_ERR]   = err_q;
        sts_byte[STS_IRQ]   = irq_q;
        sts_byte[STS_CAP0]  = cap_q[0];
        sts_byte[STS_CAP1]  = cap_q[1];
    end

    assign run    = run_q;
    assign to_mem = tomem_q;
    assign irq    = irq_q;

    logic unused_wd;
    assign unused_wd = ^{cmd_wd[7:4], cmd_wd[2:1], sts_wd[7], sts_wd[4:3], sts_wd[STS_ACT]};

    // R4: active never reads 1 without the run flag
    p_active_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> run_q);

    // R5: a command write clearing run leaves active low after the edge
    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_wd[CMD_RUN]) |=> (!act_q && !run_q));

    // R6: writing 0 to the error bit with no event keeps it
    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && !sts_wd[STS_ERR] && !err_evt) |=> $stable(err_q));

    // R6: an interrupt event always leaves the bit set
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt |=> irq_q);
endmodule

// File: rtl/bmdma_ptr.sv
// Module: descriptor table pointer register.
// Byte-writable; the low ALIGN_BITS address bits are never stored, so the
// pointer is always aligned. Assumes ALIGN_BITS < 8.
module bmdma_ptr #(
    parameter int NBYTES     = 4,
    parameter int ALIGN_BITS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBYTES-1:0]      be,
    input  logic [NBYTES-1:0][7:0] wd,
    output logic [NBYTES-1:0][7:0] ptr
);
    logic [NBYTES-1:0][7:0] ptr_q;

    for (genvar i = 0; i < NBYTES; i++) begin : g_pbyte
        localparam logic [7:0] KEEP = (i == 0) ? (8'hFF << ALIGN_BITS) : 8'hFF;
        // per-byte storage with alignment mask on the lowest byte
        always_ff @(posedge clk) begin
            if (!rst_n)     ptr_q[i] <= '0;
            else if (be[i]) ptr_q[i] <= wd[i] & KEEP;
        end
    end

    assign ptr = ptr_q;

    // R9: pointer changes only under a write
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (be == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/bmdma_regs.sv
// Module: top of the bus-master DMA control register window.
// Maps command (0), status (2) and descriptor pointer (4..7) into an
// eight-byte window; vendor offsets 1 and 3 read zero. Assumes a single
// synchronous clock domain shared with the DMA engine.
module bmdma_regs
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_dword,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        eng_run,
    output logic        eng_to_mem,
    output logic [31:0] eng_table_base,
    input  logic        eng_busy,
    input  logic        eng_err_evt,
    input  logic        eng_irq_evt,
    output logic        irq
);
    logic [WIN_BYTES-1:0]      wr_be;
    logic [WIN_BYTES-1:0][7:0] wr_bytes;
    logic [WIN_BYTES-1:0][7:0] rd_bytes;
    byte_t                     cmd_byte, sts_byte;
    logic [PTR_BYTES-1:0][7:0] ptr_bytes;

    bmdma_lane #(.NBYTES(WIN_BYTES)) u_lane (
        .wr_en    (reg_wr),
        .dword    (reg_dword),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rd_bytes (rd_bytes),
        .wr_be    (wr_be),
        .wr_bytes (wr_bytes),
        .rdata    (reg_rdata)
    );

    bmdma_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (wr_be[OFF_CMD]),
        .cmd_wd   (wr_bytes[OFF_CMD]),
        .sts_we   (wr_be[OFF_STS]),
        .sts_wd   (wr_bytes[OFF_STS]),
        .eng_busy (eng_busy),
        .err_evt  (eng_err_evt),
        .irq_evt  (eng_irq_evt),
        .cmd_byte (cmd_byte),
        .sts_byte (sts_byte),
        .run      (eng_run),
        .to_mem   (eng_to_mem),
        .irq      (irq)
    );

    bmdma_ptr #(.NBYTES(PTR_BYTES), .ALIGN_BITS(PTR_ALIGN)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .be    (wr_be[OFF_PTR +: PTR_BYTES]),
        .wd    (wr_bytes[OFF_PTR +: PTR_BYTES]),
        .ptr   (ptr_bytes)
    );

    // window read image
    always_comb begin
        rd_bytes                       = '0;
        rd_bytes[OFF_CMD]              = cmd_byte;
        rd_bytes[OFF_STS]              = sts_byte;
        rd_bytes[OFF_PTR +: PTR_BYTES] = ptr_bytes;
    end

    assign eng_table_base = ptr_bytes;

    logic unused_vendor;
    assign unused_vendor = ^{wr_bytes[OFF_VEND1], wr_bytes[OFF_VEND3]};

    // R10: a vendor-only write leaves the command byte untouched
    p_vendor_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_be[OFF_VEND1] || wr_be[OFF_VEND3]) && !wr_be[OFF_CMD]) |=> $stable(cmd_byte));

    // R7: an interrupt event raises the irq output at the next edge
    p_irq_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_irq_evt |=> irq);
endmodule

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_dword;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        eng_run, eng_to_mem, eng_busy, eng_err_evt, eng_irq_evt, irq;
    logic [31:0] eng_table_base;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bmdma_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_dword(reg_dword),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_run(eng_run), .eng_to_mem(eng_to_mem), .eng_table_base(eng_table_base),
        .eng_busy(eng_busy), .eng_err_evt(eng_err_evt), .eng_irq_evt(eng_irq_evt),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic dw, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_dword = dw; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic dw, output logic [31:0] d);
        reg_addr = a; reg_dword = dw;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_err;
        @(negedge clk); eng_err_evt = 1'b1;
        @(negedge clk); eng_err_evt = 1'b0;
    endtask

    task automatic pulse_irq;
        @(negedge clk); eng_irq_evt = 1'b1;
        @(negedge clk); eng_irq_evt = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; reg_wr = 0; reg_dword = 0; reg_addr = 0; reg_wdata = 0;
        eng_busy = 0; eng_err_evt = 0; eng_irq_evt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, 1'b1, v); chk("R1 word0", v, 32'h0);
        rd(3'd4, 1'b1, v); chk("R1 ptr", v, 32'h0);
        chk("R1 outputs", {28'h0, eng_run, eng_to_mem, irq, |eng_table_base}, 32'h0);
    endtask

    task automatic t_command;
        logic [31:0] v;
        wr(3'd0, 1'b0, 32'h09);
        chk("R2 run set", {31'h0, eng_run}, 32'h1);
        chk("R3 dir to mem", {31'h0, eng_to_mem}, 32'h1);
        rd(3'd0, 1'b0, v); chk("R2 R3 cmd read", v, 32'h09);
        wr(3'd0, 1'b0, 32'hF7);
        chk("R3 dir to dev", {31'h0, eng_to_mem}, 32'h0);
        rd(3'd0, 1'b0, v); chk("R3 other bits zero", v, 32'h01);
        wr(3'd0, 1'b0, 32'h00);
        chk("R2 run cleared", {31'h0, eng_run}, 32'h0);
    endtask

    task automatic t_active_abort;
        logic [31:0] v;
        @(negedge clk); eng_busy = 1'b1;
        @(negedge clk);
        rd(3'd2, 1'b0, v); chk("R4 busy without run", v, 32'h0);
        wr(3'd0, 1'b0, 32'h01);
        rd(3'd2, 1'b0, v); chk("R4 active", v, 32'h01);
        wr(3'd2, 1'b0, 32'h00);
        rd(3'd2, 1'b0, v); chk("R4 active not writable", v, 32'h01);
        wr(3'd0, 1'b0, 32'h00);
        rd(3'd2, 1'b0, v); chk("R5 abort drops active", v, 32'h0);
        chk("R5 abort drops run", {31'h0, eng_run}, 32'h0);
        @(negedge clk); eng_busy = 1'b0;
    endtask

    task automatic t_sticky;
        logic [31:0] v;
        pulse_err;
        rd(3'd2, 1'b0, v); chk("R6 err set", v, 32'h02);
        wr(3'd2, 1'b0, 32'h00);
        rd(3'd2, 1'b0, v); chk("R6 write 0 keeps err", v, 32'h02);
        wr(3'd2, 1'b0, 32'h02);
        rd(3'd2, 1'b0, v); chk("R6 w1c err", v, 32'h00);
        pulse_irq;
        chk("R7 irq out high", {31'h0, irq}, 32'h1);
        rd(3'd2, 1'b0, v); chk("R6 irq set", v, 32'h04);
        @(negedge clk);
        reg_wr = 1; reg_dword = 0; reg_addr = 3'd2; reg_wdata = 32'h04; eng_irq_evt = 1;
        @(negedge clk);
        reg_wr = 0; eng_irq_evt = 0;
        rd(3'd2, 1'b0, v); chk("R6 event wins over clear", v, 32'h04);
        wr(3'd2, 1'b0, 32'h04);
        chk("R7 irq out low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_capable;
        logic [31:0] v;
        wr(3'd2, 1'b0, 32'h60);
        rd(3'd2, 1'b0, v); chk("R8 both capable", v, 32'h60);
        wr(3'd2, 1'b0, 32'h20);
        rd(3'd2, 1'b0, v); chk("R8 drive0 only", v, 32'h20);
        wr(3'd2, 1'b0, 32'h9F);
        rd(3'd2, 1'b0, v); chk("R8 reserved bits zero", v, 32'h00);
    endtask

    task automatic t_pointer;
        logic [31:0] v;
        wr(3'd4, 1'b1, 32'h12345677);
        rd(3'd4, 1'b1, v); chk("R9 dword aligned", v, 32'h12345674);
        chk("R9 table base", eng_table_base, 32'h12345674);
        wr(3'd6, 1'b0, 32'h000000AB);
        rd(3'd4, 1'b1, v); chk("R9 byte write", v, 32'h12AB5674);
        wr(3'd4, 1'b0, 32'h000000FF);
        rd(3'd4, 1'b1, v); chk("R9 low byte masked", v, 32'h12AB56FC);
        rd(3'd5, 1'b0, v); chk("R11 byte read", v, 32'h00000056);
        wr(3'd7, 1'b1, 32'hCAFEBABD);
        rd(3'd6, 1'b1, v); chk("R11 dword ignores low addr", v, 32'hCAFEBABC);
    endtask

    task automatic t_vendor;
        logic [31:0] v;
        wr(3'd0, 1'b0, 32'h08);
        wr(3'd1, 1'b0, 32'hFF);
        wr(3'd3, 1'b0, 32'hFF);
        rd(3'd1, 1'b0, v); chk("R10 vendor1 zero", v, 32'h0);
        rd(3'd3, 1'b0, v); chk("R10 vendor3 zero", v, 32'h0);
        wr(3'd2, 1'b0, 32'h40);
        rd(3'd0, 1'b1, v); chk("R10 R11 word0 layout", v, 32'h00400008);
        wr(3'd0, 1'b1, 32'h0020FF09);
        rd(3'd0, 1'b1, v); chk("R11 dword write word0", v, 32'h00200009);
    endtask

    task automatic t_clean_done;
        logic [31:0] v;
        wr(3'd0, 1'b0, 32'h09);
        @(negedge clk); eng_busy = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd2, 1'b0, v); chk("R12 running", v & 32'h7, 32'h1);
        eng_busy = 1'b0; eng_irq_evt = 1'b1;
        @(negedge clk); eng_irq_evt = 1'b0;
        rd(3'd2, 1'b0, v); chk("R12 clean completion", v & 32'h7, 32'h4);
        wr(3'd0, 1'b0, 32'h08);
        wr(3'd2, 1'b0, 32'h06);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset;
        t_reset;
        t_command;
        t_active_abort;
        t_sticky;
        t_capable;
        t_pointer;
        t_vendor;
        t_clean_done;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule